// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises one parallel byte into a single asynchronous frame on a one-wire output. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit (even or odd), then one or two high stop bits. Every frame is therefore 7 to 12 bits long. The format is chosen at run time through a small configuration input. The block takes that configuration, and the byte, when it accepts the byte.

Bit timing comes from a single-cycle `baud_tick` strobe produced by a rate divider outside the block. Every bit of the frame is held for exactly one tick period. A byte is offered with a valid/ready handshake. The transmitter accepts a byte only while no frame is pending or in progress. A `busy` flag covers the time from acceptance to the end of the last stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After a byte is accepted, `txd` stays high until the next `baud_tick`. That tick starts a low start bit, and the start bit lasts one tick period.
- R2: The data bits follow the start bit least significant bit first. Their count is 5 + `cfg_len` (0→5, 1→6, 2→7, 3→8). Input bits above the configured count have no effect on the line.
- R3: When `cfg_par_en` = 1, one parity bit directly follows the last data bit. It is computed over the configured data bits only. With `cfg_par_odd` = 0 the count of ones across data and parity is even; with `cfg_par_odd` = 1 it is odd. When `cfg_par_en` = 0, no parity bit is sent.
- R4: One stop bit is sent when `cfg_two_stop` = 0 and two when it is 1, and stop bits are high. The frame spans 1 + data + parity + stop tick periods, which gives 7 to 12. `busy` falls on the tick that ends the last stop bit.
- R5: `txd` is high whenever `busy` is low.
- R6: `in_ready` is high exactly when `busy` is low. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_valid` while `busy` is high has no effect on the frame being sent.
- R7: `txd` changes only on clock edges where `baud_tick` is high.
- R8: The configuration is captured at acceptance. Changing the configuration inputs during a frame does not alter that frame.
- R9: During reset `txd` is high, `busy` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_data | input | 8 | Byte to send; LSB goes first |
| cfg_len | input | 2 | Data bit count minus five |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| busy | output | 1 | Frame pending or on the line |
| txd | output | 1 | Serial output, idles high |

## Verification
The bench targets both ends of the frame length: the shortest frame (5 data bits, no parity, one stop bit) and the longest (8 data bits, parity, two stop bits). A counter that is off by one in either direction shows up there as a wrong frame length, or as a missing or extra stop bit. A byte with its upper bits set is sent in a 5-bit format with parity. This catches parity taken over all eight bits, and high data bits that leak into the parity or stop slots. One frame is disturbed partway through: a second byte is offered and every configuration input is flipped. A design that samples the format live, or that accepts a byte while busy, produces a corrupted frame. The bench also watches for `txd` moving between ticks and for a start bit that begins at acceptance rather than at the next tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   localparam int unsigned STOP_MAX = 2;
endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MIN_DATA  = 5,
   parameter bit          PARITY_OK = 1'b1,
   parameter int unsigned LEN_W     = 2,
   parameter int unsigned BODY_W    = 11,
   parameter int unsigned CNT_W     = 4
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LEN_W-1:0]  len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   output logic [BODY_W-1:0] body,
   output logic [CNT_W-1:0]  nbits
);
   logic [CNT_W-1:0]  n_raw;
   logic [CNT_W-1:0]  n_data;
   logic [DATA_W-1:0] masked;
   logic              par_use;
   logic              par_bit;

   always_comb begin
      n_raw  = CNT_W'(MIN_DATA) + CNT_W'(len);
      n_data = (n_raw > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : n_raw;
   end

   generate
      if (PARITY_OK) begin : g_par
         assign par_use = par_en;
      end else begin : g_nopar
         assign par_use = 1'b0;
      end
   endgenerate

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign masked[gi] = data[gi] & (CNT_W'(gi) < n_data);
   end

   assign par_bit = (^masked) ^ par_odd;

   for (genvar gb = 0; gb < BODY_W; gb++) begin : g_body
      if (gb < DATA_W) begin : g_dslot
         assign body[gb] = (CNT_W'(gb) < n_data) ? data[gb]
                         : ((CNT_W'(gb) == n_data) && par_use) ? par_bit
                         : 1'b1;
      end else begin : g_tslot
         assign body[gb] = ((CNT_W'(gb) == n_data) && par_use) ? par_bit : 1'b1;
      end
   end

   assign nbits = CNT_W'(2) + n_data + CNT_W'(par_use) + CNT_W'(two_stop);
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
   import uart_tx_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             in_valid,
   input  logic [CNT_W-1:0] nbits,
   output logic             load,
   output logic             go_start,
   output logic             go_shift,
   output logic             go_end,
   output logic             busy
);
   tx_state_e        state;
   logic [CNT_W-1:0] remain;

   assign busy     = (state != TX_IDLE);
   assign load     = (state == TX_IDLE) && in_valid;
   assign go_start = (state == TX_WAIT) && baud_tick;
   assign go_shift = (state == TX_SEND) && baud_tick && (remain != CNT_W'(1));
   assign go_end   = (state == TX_SEND) && baud_tick && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= TX_IDLE;
         remain <= '0;
      end else begin
         if (load) begin
            state  <= TX_WAIT;
            remain <= nbits;
         end else if (go_start) begin
            state  <= TX_SEND;
         end else if (go_shift) begin
            remain <= remain - CNT_W'(1);
         end else if (go_end) begin
            state  <= TX_IDLE;
            remain <= '0;
         end
      end
   end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
   parameter int unsigned BODY_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              go_start,
   input  logic              go_shift,
   input  logic              go_end,
   input  logic [BODY_W-1:0] body,
   output logic              txd
);
   logic [BODY_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         txd   <= 1'b1;
      end else begin
         if (load) begin
            shreg <= body;
         end else if (go_start) begin
            txd <= 1'b0;
         end else if (go_shift) begin
            txd   <= shreg[0];
            shreg <= {1'b1, shreg[BODY_W-1:1]};
         end else if (go_end) begin
            txd <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MIN_DATA  = 5,
   parameter bit          PARITY_OK = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   baud_tick,
   input  logic                                   in_valid,
   output logic                                   in_ready,
   input  logic [DATA_W-1:0]                      in_data,
   input  logic [$clog2(DATA_W-MIN_DATA+1)-1:0]   cfg_len,
   input  logic                                   cfg_par_en,
   input  logic                                   cfg_par_odd,
   input  logic                                   cfg_two_stop,
   output logic                                   busy,
   output logic                                   txd
);
   localparam int unsigned LEN_W     = $clog2(DATA_W - MIN_DATA + 1);
   localparam int unsigned BODY_W    = DATA_W + 1 + uart_tx_pkg::STOP_MAX;
   localparam int unsigned FRAME_MAX = BODY_W + 1;
   localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

   generate
      if (MIN_DATA < 1 || MIN_DATA > DATA_W) begin : g_bad_min
         $error("uart_frame_tx: MIN_DATA must lie in 1..DATA_W");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("uart_frame_tx: data length range must span at least two values");
      end
   endgenerate

   logic [BODY_W-1:0] body;
   logic [CNT_W-1:0]  nbits;
   logic              load;
   logic              go_start;
   logic              go_shift;
   logic              go_end;
   logic              seq_busy;

   uart_tx_framer #(
      .DATA_W    (DATA_W),
      .MIN_DATA  (MIN_DATA),
      .PARITY_OK (PARITY_OK),
      .LEN_W     (LEN_W),
      .BODY_W    (BODY_W),
      .CNT_W     (CNT_W)
   ) u_framer (
      .data     (in_data),
      .len      (cfg_len),
      .par_en   (cfg_par_en),
      .par_odd  (cfg_par_odd),
      .two_stop (cfg_two_stop),
      .body     (body),
      .nbits    (nbits)
   );

   uart_tx_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .in_valid  (in_valid),
      .nbits     (nbits),
      .load      (load),
      .go_start  (go_start),
      .go_shift  (go_shift),
      .go_end    (go_end),
      .busy      (seq_busy)
   );

   uart_tx_shift #(
      .BODY_W (BODY_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .go_start (go_start),
      .go_shift (go_shift),
      .go_end   (go_end),
      .body     (body),
      .txd      (txd)
   );

   assign busy     = seq_busy;
   assign in_ready = !seq_busy;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic in_valid,
   input logic busy,
   input logic txd
);
   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd) else $error("idle line low"); // R5

   AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd)) else $error("txd moved off tick"); // R7

   AST_BUSY_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(in_valid)) else $error("frame without a byte"); // R6

   AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> txd) else $error("start bit before tick"); // R1

   AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(baud_tick)) else $error("frame ended off tick"); // R4
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .baud_tick (baud_tick),
   .in_valid  (in_valid),
   .busy      (busy),
   .txd       (txd)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int NVEC       = 8;

   // {data, len code, parity enable, odd, two stop}
   localparam logic [12:0] VEC [0:NVEC-1] = '{
      {8'h55, 2'd0, 1'b0, 1'b0, 1'b0},
      {8'hA5, 2'd3, 1'b1, 1'b0, 1'b1},
      {8'hE0, 2'd0, 1'b1, 1'b0, 1'b0},
      {8'h3C, 2'd1, 1'b1, 1'b1, 1'b0},
      {8'hFF, 2'd2, 1'b1, 1'b0, 1'b1},
      {8'h81, 2'd3, 1'b1, 1'b1, 1'b0},
      {8'h1F, 2'd0, 1'b1, 1'b1, 1'b1},
      {8'h00, 2'd3, 1'b0, 1'b0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic [1:0] cfg_len = 2'd0;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       busy;
   logic       txd;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;
   int tick_cnt = 0;

   uart_frame_tx uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .baud_tick    (baud_tick),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_data      (in_data),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_odd  (cfg_par_odd),
      .cfg_two_stop (cfg_two_stop),
      .busy         (busy),
      .txd          (txd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tick_cnt  <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
      baud_tick <= (tick_cnt == TICK_DIV-2);
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic void build(input logic [7:0] d, input logic [1:0] l, input logic pe,
                                 input logic po, input logic ts,
                                 output logic [11:0] bits, output int n);
      int nd;
      int idx;
      logic p;
      nd = 5 + int'(l);
      bits = '1;
      bits[0] = 1'b0;
      p = po;
      for (int i = 0; i < nd; i++) begin
         bits[1+i] = d[i];
         p = p ^ d[i];
      end
      idx = 1 + nd;
      if (pe) begin
         bits[idx] = p;
         idx++;
      end
      n = idx + 1 + int'(ts);
   endfunction

   task automatic send(input logic [12:0] v, input bit disturb, input string tag);
      logic [11:0] exp_bits;
      logic [11:0] got;
      int exp_n;
      int n;
      int moved;
      int guard;
      bit was_tick;
      bit prev;
      build(v[12:5], v[4:3], v[2], v[1], v[0], exp_bits, exp_n);
      @(negedge clk);
      in_valid = 1'b1;
      in_data = v[12:5];
      cfg_len = v[4:3];
      cfg_par_en = v[2];
      cfg_par_odd = v[1];
      cfg_two_stop = v[0];
      check(in_ready === 1'b1, {tag, " R6 ready before accept"}, int'(in_ready), 1);
      @(posedge clk);
      #2;
      // R1: accepted, line still high until next tick
      check(busy === 1'b1 && txd === 1'b1, {tag, " R1 R6 after accept"},
            int'({busy, txd}), 3);
      @(negedge clk);
      if (disturb) begin
         in_valid = 1'b1;
         in_data = ~v[12:5];
         cfg_len = ~v[4:3];
         cfg_par_en = ~v[2];
         cfg_par_odd = ~v[1];
         cfg_two_stop = ~v[0];
      end else begin
         in_valid = 1'b0;
      end
      got = '1;
      n = 0;
      moved = 0;
      guard = 0;
      prev = txd;
      forever begin
         @(posedge clk);
         was_tick = baud_tick;
         #2;
         guard++;
         if (!was_tick && txd !== prev) moved++;
         if (busy && in_ready) moved++;
         prev = txd;
         if (was_tick) begin
            if (!busy) break;
            if (n < 12) got[n] = txd;
            n++;
            if (disturb && n == 2) in_valid = 1'b0;
         end
         if (guard > 400) break;
      end
      in_valid = 1'b0;
      check(got === exp_bits, {tag, " R1 R2 R3 R4 R8 frame bits"}, int'(got), int'(exp_bits));
      check(n == exp_n, {tag, " R4 frame length"}, n, exp_n);
      check(moved == 0 && txd === 1'b1, {tag, " R5 R6 R7 line behaviour"}, moved, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset values
      check(txd === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R9 reset state",
            int'({txd, busy, in_ready}), 5);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(txd === 1'b1 && busy === 1'b0, "R5 idle after reset", int'({txd, busy}), 2);
      for (int k = 0; k < NVEC; k++) begin
         send(VEC[k], 1'b0, $sformatf("vec%0d", k));
      end
      // R8 and R6: byte offered and format flipped mid-frame
      send({8'h96, 2'd3, 1'b1, 1'b0, 1'b0}, 1'b1, "disturb");
      // R2: upper bits set with 6-bit length, no parity
      send({8'hC0, 2'd1, 1'b0, 1'b0, 1'b0}, 1'b0, "upper");
      // long idle then short frame
      repeat (9) @(negedge clk);
      check(txd === 1'b1 && busy === 1'b0, "R5 long idle", int'({txd, busy}), 2);
      send({8'h0A, 2'd0, 1'b1, 1'b1, 1'b0}, 1'b0, "late");
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule